// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

A behavioural, synthesizable model of a single-clock static RAM. Every command is registered on the rising edge, and reads return one cycle later through an output register. The word is four 9-bit lanes. Writes are deferred. The data of a write follows its command by one clock and waits in a one-entry buffer. The buffer reaches the array only when the next write command is taken. A read of the buffered word is served from the buffer, lane by lane, so the deferral cannot be seen at the ports.

A static mode pin, held steady after reset, sets how the top address bit (the way bit) is used. In normal mode it is one more address bit, sampled with the rest. In late-select mode a read takes the way bit one edge after the other address bits, and the bit steers a two-way mux just ahead of the output register. Writes take the way bit with the address in both modes. A sleep input freezes all state. An asynchronous output enable can release the bus at any time. The tri-state bus is modelled as a data output plus a drive-enable flag, where a low flag stands for high impedance.

Top module: `lw_sram`

## Requirements
- R1: A write command (cs_n=0, we_n=0) takes its data from din on the next rising edge. Any later read of that address returns the data.
- R2: After any sequence of writes, every address reads back its most recent data. This includes the last write, which is still held in the buffer.
- R3: A read of the buffered address returns buffered lanes for enabled lanes and array contents for the other lanes.
- R4: A read command on edge N puts its word on dq_o with dq_oe=1 after edge N+1. dq_o does not change on edges that capture no read.
- R5: be_n[i]=0 enables writing of din[9i+8:9i]. All 16 lane combinations are honoured.
- R6: A write with be_n=4'hF changes no stored data. It still takes the buffer slot, so the write before it becomes committed.
- R7: cs_n=1 on edge N is a deselect. dq_oe is 0 after edge N+1.
- R8: A write command on edge N leaves dq_oe at 0 after edge N+1.
- R9: With late_sel=1, a read takes the way bit from the way input on the edge after the command. The value on way at the command edge is ignored.
- R10: With late_sel=1, a write uses the way value present with its command as the top address bit.
- R11: With late_sel=0, a read uses the way value present with its command. The value on the following edge is ignored.
- R12: While sleep=1, dq_oe is 0 at once and no command is accepted. A write issued during sleep leaves memory unchanged.
- R13: oe_n=1 forces dq_oe to 0 without a clock edge. Returning oe_n to 0 restores the same data.
- R14: After reset dq_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| late_sel | input | 1 | Static mode: 1 selects late-select reads |
| sleep | input | 1 | Sleep: freezes state, releases bus |
| oe_n | input | 1 | Asynchronous output enable, active low |
| cs_n | input | 1 | Chip select, active low, sampled |
| we_n | input | 1 | Write command, active low, sampled |
| be_n | input | 4 | Lane write enables, active low |
| addr | input | 4 | Address without the way bit |
| way | input | 1 | Way bit (top address bit) |
| din | input | 36 | Write data, one cycle after the command |
| dq_o | output | 36 | Read data from the output register |
| dq_oe | output | 1 | Bus drive enable; 0 means high impedance |

## Verification
Back-to-back write and read sweeps over all 32 words in both modes show that the deferred buffer never loses or reorders data. In late-select mode the way pin of each read is carried by the following command, which separates the way-bit timing from the address timing. A sweep of all 16 lane masks against one word, read straight away and again after a later commit, separates the bypass merge from the array path. Pairs of reads whose way differs between the command edge and the next edge show which edge each mode samples. Deselect, write, sleep and output-enable cycles each show whether the bus release comes from the synchronous pipeline or the asynchronous path.

// File: rtl/lw_sram.sv
module lw_sram #(
  parameter int AW = 5,
  parameter int LANES = 4,
  parameter int LW = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  late_sel,
  input  logic                  sleep,
  input  logic                  oe_n,
  input  logic                  cs_n,
  input  logic                  we_n,
  input  logic [LANES-1:0]      be_n,
  input  logic [AW-2:0]         addr,
  input  logic                  way,
  input  logic [LANES*LW-1:0]   din,
  output logic [LANES*LW-1:0]   dq_o,
  output logic                  dq_oe
);
  localparam int DW = LANES * LW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  logic             ph_v, bf_v, rd_v, rd_way, drv;
  logic [AW-1:0]    ph_a, bf_a;
  logic [LANES-1:0] ph_m, bf_m;
  logic [DW-1:0]    bf_d;
  logic [AW-2:0]    rd_lo;

  function automatic logic [DW-1:0] expand(input logic [LANES-1:0] m);
    for (int l = 0; l < LANES; l++) expand[l*LW +: LW] = {LW{m[l]}};
  endfunction

  wire rd_go = !sleep && !cs_n && we_n;
  wire wr_go = !sleep && !cs_n && !we_n;

  wire             cm_v = wr_go && (ph_v || bf_v);
  wire [AW-1:0]    cm_a = ph_v ? ph_a : bf_a;
  wire [LANES-1:0] cm_m = ph_v ? ph_m : bf_m;
  wire [DW-1:0]    cm_d = ph_v ? din  : bf_d;

  wire [AW-1:0] rd_full = {late_sel ? way : rd_way, rd_lo};
  wire [DW-1:0] bmask   = expand(bf_m);
  wire          hit     = bf_v && (bf_a == rd_full);
  wire [DW-1:0] rd_word = hit ? ((mem[rd_full] & ~bmask) | (bf_d & bmask)) : mem[rd_full];

  assign dq_oe = drv && !oe_n && !sleep;

  always_ff @(posedge clk) begin
    if (cm_v)
      for (int l = 0; l < LANES; l++)
        if (cm_m[l]) mem[cm_a][l*LW +: LW] <= cm_d[l*LW +: LW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_v <= 1'b0; ph_a <= '0; ph_m <= '0;
      bf_v <= 1'b0; bf_a <= '0; bf_m <= '0; bf_d <= '0;
      rd_v <= 1'b0; rd_lo <= '0; rd_way <= 1'b0;
      drv  <= 1'b0; dq_o <= '0;
    end else if (sleep) begin
      drv <= 1'b0;
    end else begin
      ph_v <= wr_go;
      if (wr_go) begin
        ph_a <= {way, addr};
        ph_m <= ~be_n;
      end
      if (ph_v) begin
        bf_v <= 1'b1;
        bf_a <= ph_a;
        bf_m <= ph_m;
        bf_d <= din;
      end
      rd_v <= rd_go;
      if (rd_go) begin
        rd_lo  <= addr;
        rd_way <= way;
      end
      drv <= rd_v;
      if (rd_v) dq_o <= rd_word;
    end
  end

  a_r7_deselect_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && cs_n) |=> ##1 !dq_oe);

  a_r8_write_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> ##1 !dq_oe);

  a_r4_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go ##1 !sleep |=> (dq_oe || oe_n || sleep));

  a_r4_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_v |=> $stable(dq_o));

  a_r12_sleep_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> ($stable(bf_d) && $stable(bf_a) && $stable(ph_v) && $stable(dq_o)));
endmodule

// File: tb/lw_sram_tb.sv
`timescale 1ns/1ps
module lw_sram_tb;
  logic clk = 0, rst_n = 0, late_sel = 0, sleep = 0, oe_n = 0, cs_n = 1, we_n = 1, way = 0;
  logic [3:0]  be_n = 4'hF, addr = 0;
  logic [35:0] din = 0, dq_o;
  logic        dq_oe;
  logic [35:0] exp_m [32];
  logic [35:0] pend_d = 0;
  int nchk = 0, nfail = 0;

  lw_sram u_dut (.clk, .rst_n, .late_sel, .sleep, .oe_n, .cs_n, .we_n,
                 .be_n, .addr, .way, .din, .dq_o, .dq_oe);

  always #10 clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  function automatic logic [35:0] pat(input int i);
    return 36'(i * 36'h0_1234_5677) ^ 36'h9_A5C3_1F0E;
  endfunction

  task automatic chk(input string r, input logic [35:0] act, input logic [35:0] e);
    nchk++;
    if (act !== e) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", r, act, e);
    end
  endtask

  task automatic step(input logic c, input logic w, input logic [3:0] b,
                      input logic [3:0] a, input logic wy);
    cs_n = c; we_n = w; be_n = b; addr = a; way = wy; din = pend_d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wcmd(input int fa, input logic [3:0] b, input logic [35:0] d);
    step(0, 0, b, 4'(fa), fa[4]);
    pend_d = d;
    for (int l = 0; l < 4; l++)
      if (!b[l]) exp_m[fa][l*9 +: 9] = d[l*9 +: 9];
  endtask

  task automatic rd_chk(input int fa, input string r);
    step(0, 1, 4'hF, 4'(fa), late_sel ? ~fa[4] : fa[4]);
    step(1, 1, 4'hF, 4'h0, late_sel ? fa[4] : ~fa[4]);
    chk(r, {35'd0, dq_oe}, 36'd1);
    chk(r, dq_o, exp_m[fa]);
  endtask

  task automatic do_reset(input logic mode);
    rst_n = 0; late_sel = mode; cs_n = 1;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R14", {35'd0, dq_oe}, 36'd0);
  endtask

  initial begin
    do_reset(0);
    // R1 R2: back-to-back write sweep, then back-to-back read sweep
    for (int i = 0; i < 32; i++) wcmd(i, 4'h0, pat(i));
    for (int i = 0; i < 32; i++) begin
      step(0, 1, 4'hF, 4'(i), i[4]);
      if (i > 0) chk("R2", dq_o, exp_m[i-1]);
    end
    step(1, 1, 4'hF, 0, 0);
    chk("R2", dq_o, exp_m[31]);
    chk("R4", {35'd0, dq_oe}, 36'd1);
    step(1, 1, 4'hF, 0, 0);
    chk("R7", {35'd0, dq_oe}, 36'd0);
    // R8: write then idle, bus released in data cycle
    wcmd(2, 4'h0, 36'h1_1111_1111);
    step(1, 1, 4'hF, 0, 0);
    chk("R8", {35'd0, dq_oe}, 36'd0);
    rd_chk(2, "R1");
    // R3: partial write over a full one, read straight from the buffer
    wcmd(7, 4'h0, 36'hF_0F0F_0F0F);
    wcmd(7, 4'b1010, 36'h0_ABCD_EF12);
    rd_chk(7, "R3");
    // R5: all lane masks, bypass path then committed path
    for (int b = 0; b < 16; b++) begin
      wcmd(9, 4'(b), pat(100 + b));
      rd_chk(9, "R5");
      wcmd(10, 4'h0, pat(200 + b));
      rd_chk(9, "R5");
    end
    // R6: empty-mask write changes nothing and commits its predecessor
    wcmd(12, 4'h0, 36'h5_5555_5555);
    wcmd(12, 4'hF, 36'hA_AAAA_AAAA);
    rd_chk(12, "R6");
    wcmd(13, 4'h0, 36'h3_3333_3333);
    rd_chk(12, "R6");
    rd_chk(13, "R6");
    // R11: normal mode takes way with the command
    wcmd(5, 4'h0, 36'h0_0000_0AAA);
    wcmd(21, 4'h0, 36'h0_0000_0BBB);
    rd_chk(5, "R11");
    rd_chk(21, "R11");
    // R13: asynchronous output enable
    step(0, 1, 4'hF, 4'd5, 1'b0);
    step(1, 1, 4'hF, 0, 0);
    oe_n = 1; #1;
    chk("R13", {35'd0, dq_oe}, 36'd0);
    oe_n = 0; #1;
    chk("R13", {35'd0, dq_oe}, 36'd1);
    chk("R13", dq_o, exp_m[5]);
    // R12: sleep releases bus and blocks a write
    sleep = 1; #1;
    chk("R12", {35'd0, dq_oe}, 36'd0);
    step(0, 0, 4'h0, 4'd6, 1'b0);
    pend_d = 36'hD_EAD0_BEEF;
    step(1, 1, 4'hF, 0, 0);
    sleep = 0;
    rd_chk(6, "R12");
    // flush buffer with an empty-mask write before re-reset
    wcmd(0, 4'hF, 36'h0);
    step(1, 1, 4'hF, 0, 0);
    do_reset(1);
    // R10 R9: late-select writes and reads
    wcmd(3, 4'h0, 36'h0_3030_3030);
    wcmd(19, 4'h0, 36'h1_9191_9191);
    rd_chk(3, "R9");
    rd_chk(19, "R9");
    rd_chk(19, "R10");
    rd_chk(5, "R10");
    rd_chk(21, "R10");
    // R9: back-to-back late-select sweep, way carried by the next command
    for (int i = 0; i < 32; i++) begin
      step(0, 1, 4'hF, 4'(i), (i > 0) ? ((i - 1) >> 4) != 0 : 1'b0);
      if (i > 0) chk("R9", dq_o, exp_m[i-1]);
    end
    step(1, 1, 4'hF, 0, 1'b1);
    chk("R9", dq_o, exp_m[31]);
    // R3 in late-select mode: bypass uses the late way bit
    wcmd(24, 4'b0101, 36'h7_7777_7777);
    rd_chk(24, "R3");
    rd_chk(8, "R3");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule